// File: doc/BRIEF.md
# Serial GPIO Input Interrupt Unit

This block produces interrupts from the input side of a serial GPIO chain. The inputs form a grid of bit indices by ports: up to four bit indices, each with up to 32 ports. After each full scan, the shift logic delivers a new vector of samples together with a one-cycle capture strobe. For each input, the unit compares the new sample with the sample it saw on the previous strobe, or it tests the new sample against a programmed level. When the selected condition is met, the unit latches a pending flag.

Software works through 32-bit words, one word per bit index, with bit p of each word belonging to port p. It uses these words to choose the trigger type of each input, to enable inputs, to clear pending flags and to read which enabled inputs are pending. A master enable in a configuration word gates the single combined interrupt line.

Top module: `sio_irq_unit`

## Requirements
- R1: After reset every readable word reads 0, no input is pending, and `irq` is 0. The stored previous sample of every input is 0.
- R2: The polarity, trigger and enable words read back what was last written to them. The configuration word is at word 0x04 and keeps only bit 0, the master enable; its other bits read 0. The acknowledge words read 0. A write to an identity word changes nothing.
- R3: The trigger type of input (b,p) is two bits. Its low bit is bit p of trigger word 0x32+b and its high bit is bit p of trigger word 0x36+b. The values are 0 = level, 1 = either edge, 2 = falling edge, 3 = rising edge.
- R4: In level mode the input becomes pending on every strobe whose new sample equals the active level. The active level is high when the polarity bit (word 0x2A+b) is 0 and low when it is 1. The condition is tested again on every strobe for as long as it holds.
- R5: In the edge modes the input becomes pending on a strobe where the new sample differs from the previous one: any change for type 1, 1 to 0 for type 2, 0 to 1 for type 3.
- R6: Samples count only in a cycle with `cap_stb` high. Without a strobe, no flag is set and the stored previous samples do not change.
- R7: Writing a word to acknowledge word 0x3A+b clears the pending flag of every port whose bit is 1 in that word. Bits written as 0 leave their flags as they are.
- R8: If an acknowledge and a new event reach the same input in the same cycle, the flag stays set.
- R9: Identity word 0x42+b reads the pending flags of bit index b ANDed with enable word 0x3E+b. A flag is latched even while its input is disabled, so enabling the input later reveals it.
- R10: `irq` is 1 exactly when the master enable is 1 and at least one identity bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_stb | input | 1 | Capture strobe: a new sample vector is valid |
| cap_data | input | NBITS*NPORTS | New samples; bit b*NPORTS+p is input (b,p) |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes, capture strobes and acknowledges take effect at the clock edge on which they are presented. The identity words and `irq` therefore show the result one clock after the stimulus, and reads return combinationally. The bench drives each operation at a falling edge and updates its model at the following rising edge. It then reads the identity words and `irq` just after that edge, before the next operation is driven. The case of an acknowledge and an event in the same cycle is driven as a single operation, so that both reach the same edge.

// File: rtl/sio_irq_unit.sv
module sio_irq_unit #(
  parameter int NBITS  = 4,
  parameter int NPORTS = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [6:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic                      cap_stb,
  input  logic [NBITS*NPORTS-1:0]   cap_data,
  output logic                      irq
);
  localparam int CFG_A  = 'h04;
  localparam int POL_A  = 'h2A;
  localparam int TRG_A  = 'h32;
  localparam int TRG_HI = 4;
  localparam int ACK_A  = 'h3A;
  localparam int ENA_A  = 'h3E;
  localparam int IDN_A  = 'h42;
  localparam int BW     = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [NPORTS-1:0] pol [NBITS];
  logic [NPORTS-1:0] tlo [NBITS];
  logic [NPORTS-1:0] thi [NBITS];
  logic [NPORTS-1:0] ena [NBITS];
  logic [NPORTS-1:0] pend [NBITS];
  logic [NPORTS-1:0] prev [NBITS];
  logic [NPORTS-1:0] ev [NBITS];
  logic [NPORTS-1:0] ackm [NBITS];
  logic [NPORTS-1:0] idn [NBITS];
  logic              mie;
  logic [NBITS*NPORTS-1:0] pend_flat, idn_flat;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [NPORTS-1:0] s, lvl, chg, fal, ris;
    assign s   = cap_data[b*NPORTS +: NPORTS];
    assign lvl = s ^ pol[b];
    assign chg = s ^ prev[b];
    assign fal = prev[b] & ~s;
    assign ris = ~prev[b] & s;
    assign ev[b] = {NPORTS{cap_stb}} &
                   ((~thi[b] & ~tlo[b] & lvl) | (~thi[b] & tlo[b] & chg) |
                    ( thi[b] & ~tlo[b] & fal) | ( thi[b] & tlo[b] & ris));
    assign ackm[b] = (reg_we && reg_addr == 7'(ACK_A + b)) ? reg_wdata[NPORTS-1:0] : '0;
    assign idn[b]  = pend[b] & ena[b];
    assign pend_flat[b*NPORTS +: NPORTS] = pend[b];
    assign idn_flat[b*NPORTS +: NPORTS]  = idn[b];
  end

  assign irq = mie & (|idn_flat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mie <= 1'b0;
      for (int b = 0; b < NBITS; b++) begin
        pol[b] <= '0; tlo[b] <= '0; thi[b] <= '0;
        ena[b] <= '0; pend[b] <= '0; prev[b] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == 7'(CFG_A)) mie <= reg_wdata[0];
      for (int b = 0; b < NBITS; b++) begin
        if (reg_we && reg_addr == 7'(POL_A + b))          pol[b] <= reg_wdata[NPORTS-1:0];
        if (reg_we && reg_addr == 7'(TRG_A + b))          tlo[b] <= reg_wdata[NPORTS-1:0];
        if (reg_we && reg_addr == 7'(TRG_A + TRG_HI + b)) thi[b] <= reg_wdata[NPORTS-1:0];
        if (reg_we && reg_addr == 7'(ENA_A + b))          ena[b] <= reg_wdata[NPORTS-1:0];
        pend[b] <= ev[b] | (pend[b] & ~ackm[b]);
        if (cap_stb) prev[b] <= cap_data[b*NPORTS +: NPORTS];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 7'(CFG_A)) reg_rdata[0] = mie;
    for (int b = 0; b < NBITS; b++) begin
      if (reg_addr == 7'(POL_A + b))          reg_rdata[NPORTS-1:0] = pol[b];
      if (reg_addr == 7'(TRG_A + b))          reg_rdata[NPORTS-1:0] = tlo[b];
      if (reg_addr == 7'(TRG_A + TRG_HI + b)) reg_rdata[NPORTS-1:0] = thi[b];
      if (reg_addr == 7'(ENA_A + b))          reg_rdata[NPORTS-1:0] = ena[b];
      if (reg_addr == 7'(IDN_A + b))          reg_rdata[NPORTS-1:0] = idn[b];
    end
  end

  logic          ack_hit;
  logic [6:0]    ack_off;
  logic [BW-1:0] ack_idx;
  assign ack_off = reg_addr - 7'(ACK_A);
  assign ack_idx = ack_off[BW-1:0];
  assign ack_hit = reg_we && (reg_addr >= 7'(ACK_A)) && (reg_addr < 7'(ACK_A + NBITS));

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 7'(CFG_A)) |=> (mie == $past(reg_wdata[0])));
  p_no_set_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> ((pend_flat & ~$past(pend_flat)) == '0));
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !cap_stb) |=> ((pend[$past(ack_idx)] & $past(reg_wdata[NPORTS-1:0])) == '0));
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_stb && !ack_hit) |=> $stable(pend_flat));
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend_flat));
endmodule

// File: tb/sio_irq_unit_test.sv
module sio_irq_unit_test;
  localparam int NB = 4;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cap_stb = 1'b0;
  logic [NB*NP-1:0] cap_data = '0;
  logic irq;

  always #5 clk = ~clk;

  sio_irq_unit #(.NBITS(NB), .NPORTS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_stb(cap_stb),
    .cap_data(cap_data), .irq(irq));

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pol [NB], m_tlo [NB], m_thi [NB], m_ena [NB], m_pend [NB], m_prev [NB];
  logic m_mie;

  function automatic logic [31:0] events(int b, logic [NB*NP-1:0] sd);
    logic [31:0] s, r;
    s = sd[b*NP +: NP];
    r = '0;
    for (int p = 0; p < NP; p++) begin
      case ({m_thi[b][p], m_tlo[b][p]})
        2'd0: r[p] = s[p] ^ m_pol[b][p];
        2'd1: r[p] = s[p] ^ m_prev[b][p];
        2'd2: r[p] = m_prev[b][p] & ~s[p];
        default: r[p] = ~m_prev[b][p] & s[p];
      endcase
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic step(logic we, logic [6:0] a, logic [31:0] d, logic stb, logic [NB*NP-1:0] sd);
    logic [31:0] ev [NB];
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; cap_stb = stb; cap_data = sd;
    for (int b = 0; b < NB; b++) ev[b] = stb ? events(b, sd) : '0;
    @(posedge clk);
    #1;
    reg_we = 1'b0; cap_stb = 1'b0;
    if (we && a == 7'h04) m_mie = d[0];
    for (int b = 0; b < NB; b++) begin
      if (we && a == 7'(8'h2A + b)) m_pol[b] = d;
      if (we && a == 7'(8'h32 + b)) m_tlo[b] = d;
      if (we && a == 7'(8'h36 + b)) m_thi[b] = d;
      if (we && a == 7'(8'h3E + b)) m_ena[b] = d;
      m_pend[b] = ev[b] | (m_pend[b] & ~((we && a == 7'(8'h3A + b)) ? d : 32'h0));
      if (stb) m_prev[b] = sd[b*NP +: NP];
    end
  endtask

  task automatic check_out(string tag);
    logic [31:0] v;
    logic any;
    any = 1'b0;
    for (int b = 0; b < NB; b++) begin
      rd(7'(8'h42 + b), v);
      check({tag, " ident"}, v, m_pend[b] & m_ena[b]);
      any = any | (|(m_pend[b] & m_ena[b]));
    end
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_mie & any});
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, cap_data);
  endtask

  task automatic cap(logic [NB*NP-1:0] sd);
    step(1'b0, 7'h0, 32'h0, 1'b1, sd);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20417));
    m_mie = 1'b0;
    for (int b = 0; b < NB; b++) begin
      m_pol[b] = '0; m_tlo[b] = '0; m_thi[b] = '0; m_ena[b] = '0; m_pend[b] = '0; m_prev[b] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 'h48; a++) begin
      rd(7'(a), v);
      check("R1 reset word", v, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 readback
    wr(7'h2B, 32'hA5A5_0F0F); rd(7'h2B, v); check("R2 polarity", v, 32'hA5A5_0F0F);
    wr(7'h37, 32'h1234_5678); rd(7'h37, v); check("R2 trigger", v, 32'h1234_5678);
    wr(7'h41, 32'hFFFF_0001); rd(7'h41, v); check("R2 enable", v, 32'hFFFF_0001);
    wr(7'h04, 32'hFFFF_FFFF); rd(7'h04, v); check("R2 config", v, 32'h1);
    wr(7'h3A, 32'hFFFF_FFFF); rd(7'h3A, v); check("R2 ack reads 0", v, 32'h0);
    wr(7'h43, 32'hFFFF_FFFF); check_out("R2 ident write ignored");
    wr(7'h2B, 0); wr(7'h37, 0); wr(7'h41, 0);

    // R3 falling via high word only: input (2,5)
    wr(7'h3E + 2, 32'h20); wr(7'h36 + 2, 32'h20);
    cap(128'h1 << (2*32 + 5)); check_out("R3 rise ignored in falling mode");
    cap('0); check_out("R3 falling via high word");
    wr(7'h3A + 2, 32'h20); check_out("R7 ack clears");

    // R5 rising on (0,0), either on (0,1)
    wr(7'h3E, 32'h3); wr(7'h32, 32'h3); wr(7'h36, 32'h1);
    cap(128'h1); check_out("R5 rising and either edges");
    wr(7'h3A, 32'h1); check_out("R7 partial ack");
    cap(128'h2); check_out("R5 second edges");
    wr(7'h3A, 32'h3);

    // R4 level low on (1,3)
    wr(7'h2B, 32'h8); wr(7'h3F, 32'h8);
    cap({NB*NP{1'b1}}); check_out("R4 inactive level");
    cap('0); check_out("R4 active low");
    wr(7'h3A + 1, 32'h8); check_out("R7 level ack");
    cap('0); check_out("R4 persists");

    // R8 ack and event together
    step(1'b1, 7'h3A + 1, 32'h8, 1'b1, '0); check_out("R8 event wins");
    // R6 no strobe
    wr(7'h3A + 1, 32'h8);
    step(1'b0, 7'h0, 0, 1'b0, {NB*NP{1'b1}}); check_out("R6 no strobe");

    // R9 latched while disabled, R10 master gate
    wr(7'h3F, 32'h0); cap('0); check_out("R9 disabled hides");
    wr(7'h3F, 32'h8); check_out("R9 enable reveals");
    wr(7'h04, 32'h0); check_out("R10 master off");
    wr(7'h04, 32'h1); check_out("R10 master on");

    // R3 random mix over all modes
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [6:0] a;
      logic [NB*NP-1:0] sd;
      op = int'($urandom_range(0, 9));
      sd = {$urandom(), $urandom(), $urandom(), $urandom()};
      case ($urandom_range(0, 5))
        0: a = 7'(8'h2A + $urandom_range(0, 3));
        1: a = 7'(8'h32 + $urandom_range(0, 7));
        2: a = 7'(8'h3E + $urandom_range(0, 3));
        3: a = 7'h04;
        default: a = 7'(8'h3A + $urandom_range(0, 3));
      endcase
      if (op < 4) step(1'b1, a, $urandom(), 1'b0, cap_data);
      else if (op < 8) step(1'b0, 7'h0, 0, 1'b1, sd);
      else step(1'b1, a, $urandom(), 1'b1, sd);
      check_out("R3 R9 R10 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule